// File: doc/BRIEF.md
# Byte-Serial DMA Channel Programming Front End

This block is the register side of a multichannel DMA engine. A host reaches it through two byte-wide locations on a simple register bus. One is a command location and the other is a data location. The host writes a command byte, which names an operation and a channel. It then moves the operands of that operation through the data location one byte at a time. An internal byte pointer decides which byte of the target register each access touches.

Each channel keeps the following state, and all of it is driven out as flat output buses:
- a 16-bit I/O port address
- a 24-bit memory address
- a 16-bit transfer count
- a mode byte
- a mask bit

The engine that moves data reads these outputs. A per-channel active flag tells it which channels may run. Data movement and arbitration live outside this block.

The sequencer is a small state machine. **IDLE** means no operand sequence is open. **LD_PORT**, **LD_ADDR**, **LD_CNT** and **LD_MODE** each accept data-port writes for one register. **RB_ADDR** and **RB_CNT** each serve data-port reads. The transitions are as follows:
- *Command decode*: any state moves to the state named by the opcode, or to IDLE for mask, unmask, unknown opcodes and out-of-range channels. The byte pointer is cleared.
- *Operand step*: a matching data access advances the pointer.
- *Sequence end*: the access that consumes the last byte returns the machine to IDLE.

Top module: `dma_cmdport_regs`

## Requirements
- R1: After reset every channel is masked. Every port, address, count and mode register reads zero, and `rdata` is 0x00.
- R2: A command byte carries the opcode in bits 7:4 and the channel in bits 3:0. Every command write clears the byte pointer, so a new command restarts operand transfer at byte 0.
- R3: Opcode 0x0 takes two data-port writes into the channel's I/O port address, low byte first.
- R4: Opcode 0x2 takes three data-port writes into the 24-bit memory address, in the order bits 7:0, 15:8, 23:16.
- R5: Opcode 0x4 takes two data-port writes, low byte first, into the 16-bit count. The count is stored exactly as written: the number of transfer units minus one (0xFFFF means 65536 units). The units are bytes, or words when mode bit 6 is set.
- R6: Opcode 0x7 takes one data-port write into the mode byte. The mode bits mean:
  - bit 2: transfer enable
  - bit 3: read (1) or write (0)
  - bit 0: I/O-port target
  - bit 6: 16-bit units
- R7: Opcode 0x3 returns the address and opcode 0x5 returns the count, one byte per data-port read, low byte first. Each byte appears on `rdata` in the cycle after the read.
- R8: Opcode 0x9 sets the channel's mask bit and opcode 0xA clears it. Both take effect in the cycle after the command write.
- R9: `ch_active[i]` is high only while channel i is unmasked and its mode bit 2 is set.
- R10: Data-port accesses that do not match the open operation are ignored, and such reads return 0x00. This covers accesses beyond the opcode's byte length, writes during a read-back and reads during a load.
- R11: A command with any other opcode changes no channel state and closes any open sequence.
- R12: Channel state changes only in a cycle with `wr_en` high. A read of the command location returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe, one byte per cycle; wins over rd_en |
| rd_en | input | 1 | Host read strobe |
| addr_sel | input | 1 | 0 = command location, 1 = data location |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Read byte, valid the cycle after rd_en |
| ch_port | output | NCH*16 | I/O port address per channel |
| ch_addr | output | NCH*24 | Memory address per channel |
| ch_count | output | NCH*16 | Count (units minus one) per channel |
| ch_mode | output | NCH*8 | Mode byte per channel |
| ch_mask | output | NCH | Mask bit per channel |
| ch_active | output | NCH | Channel may run |

## Verification
The bench targets the byte pointer, which is where such a front end usually goes wrong. A command is reissued in the middle of an address load. A design that keeps the old pointer would put the new bytes in the wrong lanes. Extra writes and reads run past the operand length. A design that wraps the pointer would overwrite byte 0 or return stale data instead of 0x00. Loads and read-backs are also crossed, and unknown opcodes follow an open sequence. A decoder that falls back to the last valid state would let later data bytes corrupt a register. Finally, the mode transfer bit and the mask are toggled independently, to catch an active flag that looks at only one of them.

// File: rtl/dma_cp_pkg.sv
package dma_cp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LD_PORT,
        ST_LD_ADDR,
        ST_LD_CNT,
        ST_LD_MODE,
        ST_RB_ADDR,
        ST_RB_CNT
    } cp_state_e;

    localparam logic [3:0] OP_LD_PORT = 4'h0;
    localparam logic [3:0] OP_LD_ADDR = 4'h2;
    localparam logic [3:0] OP_RB_ADDR = 4'h3;
    localparam logic [3:0] OP_LD_CNT  = 4'h4;
    localparam logic [3:0] OP_RB_CNT  = 4'h5;
    localparam logic [3:0] OP_LD_MODE = 4'h7;
    localparam logic [3:0] OP_MASK    = 4'h9;
    localparam logic [3:0] OP_UNMASK  = 4'hA;

    localparam int MODE_XFER_BIT = 2;
    localparam int PORT_W = 16;
    localparam int ADDR_W = 24;
    localparam int CNT_W  = 16;
    localparam int MODE_W = 8;

    // index of the final operand byte for each sequence state
    function automatic logic [1:0] last_byte(cp_state_e s);
        case (s)
            ST_LD_PORT, ST_LD_CNT, ST_RB_CNT: last_byte = 2'd1;
            ST_LD_ADDR, ST_RB_ADDR:           last_byte = 2'd2;
            default:                          last_byte = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/cp_sequencer.sv
module cp_sequencer
    import dma_cp_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic       addr_sel,
    input  logic [7:0] wdata,
    output logic [3:0] tgt_ch,
    output logic [1:0] byte_idx,
    output logic       ld_port,
    output logic       ld_addr,
    output logic       ld_cnt,
    output logic       ld_mode,
    output logic       mask_set,
    output logic       mask_clr,
    output logic       rb_go,
    output logic       rb_is_cnt
);

    cp_state_e  state_q, state_d;
    logic [3:0] ch_q, ch_d;
    logic [1:0] ptr_q, ptr_d;

    logic cmd_wr, dat_wr, dat_rd, ch_ok, is_load, is_rb, hit;

    assign cmd_wr = wr_en && !addr_sel;
    assign dat_wr = wr_en && addr_sel;
    assign dat_rd = rd_en && !wr_en && addr_sel;
    assign ch_ok  = int'(wdata[3:0]) < NCH;

    assign is_load = (state_q == ST_LD_PORT) || (state_q == ST_LD_ADDR) ||
                     (state_q == ST_LD_CNT)  || (state_q == ST_LD_MODE);
    assign is_rb   = (state_q == ST_RB_ADDR) || (state_q == ST_RB_CNT);
    assign hit     = (dat_wr && is_load) || (dat_rd && is_rb);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ch_q    <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ch_q    <= ch_d;
            ptr_q   <= ptr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        ch_d    = ch_q;
        ptr_d   = ptr_q;
        if (cmd_wr) begin
            ptr_d = '0;
            ch_d  = wdata[3:0];
            if (!ch_ok) begin
                state_d = ST_IDLE;
            end else begin
                unique case (wdata[7:4])
                    OP_LD_PORT: state_d = ST_LD_PORT;
                    OP_LD_ADDR: state_d = ST_LD_ADDR;
                    OP_LD_CNT:  state_d = ST_LD_CNT;
                    OP_LD_MODE: state_d = ST_LD_MODE;
                    OP_RB_ADDR: state_d = ST_RB_ADDR;
                    OP_RB_CNT:  state_d = ST_RB_CNT;
                    default:    state_d = ST_IDLE;
                endcase
            end
        end else if (hit) begin
            if (ptr_q == last_byte(state_q)) begin
                state_d = ST_IDLE;
            end else begin
                ptr_d = ptr_q + 2'd1;
            end
        end
    end

    always_comb begin
        tgt_ch    = ch_q;
        byte_idx  = ptr_q;
        ld_port   = 1'b0;
        ld_addr   = 1'b0;
        ld_cnt    = 1'b0;
        ld_mode   = 1'b0;
        mask_set  = 1'b0;
        mask_clr  = 1'b0;
        rb_go     = 1'b0;
        rb_is_cnt = 1'b0;
        if (cmd_wr) begin
            tgt_ch   = wdata[3:0];
            mask_set = ch_ok && (wdata[7:4] == OP_MASK);
            mask_clr = ch_ok && (wdata[7:4] == OP_UNMASK);
        end else if (dat_wr) begin
            unique case (state_q)
                ST_LD_PORT: ld_port = 1'b1;
                ST_LD_ADDR: ld_addr = 1'b1;
                ST_LD_CNT:  ld_cnt  = 1'b1;
                ST_LD_MODE: ld_mode = 1'b1;
                default: ;
            endcase
        end else if (dat_rd) begin
            unique case (state_q)
                ST_RB_ADDR: rb_go = 1'b1;
                ST_RB_CNT: begin
                    rb_go     = 1'b1;
                    rb_is_cnt = 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/cp_chan_regs.sv
module cp_chan_regs
    import dma_cp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_port,
    input  logic              ld_addr,
    input  logic              ld_cnt,
    input  logic              ld_mode,
    input  logic              mask_set,
    input  logic              mask_clr,
    input  logic [1:0]        byte_idx,
    input  logic [7:0]        wdata,
    output logic [PORT_W-1:0] port_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [MODE_W-1:0] mode_q,
    output logic              mask_q,
    output logic              active
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_q <= '0;
            addr_q <= '0;
            cnt_q  <= '0;
            mode_q <= '0;
            mask_q <= 1'b1;
        end else begin
            if (ld_port) begin
                if (byte_idx[0]) port_q[15:8] <= wdata;
                else             port_q[7:0]  <= wdata;
            end
            if (ld_addr) begin
                case (byte_idx)
                    2'd0:    addr_q[7:0]   <= wdata;
                    2'd1:    addr_q[15:8]  <= wdata;
                    default: addr_q[23:16] <= wdata;
                endcase
            end
            if (ld_cnt) begin
                if (byte_idx[0]) cnt_q[15:8] <= wdata;
                else             cnt_q[7:0]  <= wdata;
            end
            if (ld_mode) mode_q <= wdata;
            if (mask_set)      mask_q <= 1'b1;
            else if (mask_clr) mask_q <= 1'b0;
        end
    end

    assign active = !mask_q && mode_q[MODE_XFER_BIT];

endmodule

// File: rtl/cp_readback.sv
module cp_readback
    import dma_cp_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  logic                  wr_en,
    input  logic                  rb_go,
    input  logic                  rb_is_cnt,
    input  logic [3:0]            ch,
    input  logic [1:0]            byte_idx,
    input  logic [NCH*ADDR_W-1:0] addr_flat,
    input  logic [NCH*CNT_W-1:0]  cnt_flat,
    output logic [7:0]            rdata
);

    logic [ADDR_W-1:0] a_sel;
    logic [CNT_W-1:0]  c_sel;
    logic [7:0]        pick;

    always_comb begin
        a_sel = '0;
        c_sel = '0;
        for (int i = 0; i < NCH; i++) begin
            if (int'(ch) == i) begin
                a_sel = addr_flat[i*ADDR_W +: ADDR_W];
                c_sel = cnt_flat[i*CNT_W +: CNT_W];
            end
        end
    end

    always_comb begin
        if (rb_is_cnt) begin
            pick = byte_idx[0] ? c_sel[15:8] : c_sel[7:0];
        end else begin
            case (byte_idx)
                2'd0:    pick = a_sel[7:0];
                2'd1:    pick = a_sel[15:8];
                default: pick = a_sel[23:16];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 8'h00;
        end else if (rd_en && !wr_en) begin
            rdata <= rb_go ? pick : 8'h00;
        end
    end

endmodule

// File: rtl/dma_cmdport_regs.sv
module dma_cmdport_regs
    import dma_cp_pkg::*;
#(
    parameter int NCH = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic                  addr_sel,
    input  logic [7:0]            wdata,
    output logic [7:0]            rdata,
    output logic [NCH*PORT_W-1:0] ch_port,
    output logic [NCH*ADDR_W-1:0] ch_addr,
    output logic [NCH*CNT_W-1:0]  ch_count,
    output logic [NCH*MODE_W-1:0] ch_mode,
    output logic [NCH-1:0]        ch_mask,
    output logic [NCH-1:0]        ch_active
);

    logic [3:0] tgt_ch;
    logic [1:0] byte_idx;
    logic ld_port, ld_addr, ld_cnt, ld_mode, mask_set, mask_clr, rb_go, rb_is_cnt;

    cp_sequencer #(.NCH(NCH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr_sel  (addr_sel),
        .wdata     (wdata),
        .tgt_ch    (tgt_ch),
        .byte_idx  (byte_idx),
        .ld_port   (ld_port),
        .ld_addr   (ld_addr),
        .ld_cnt    (ld_cnt),
        .ld_mode   (ld_mode),
        .mask_set  (mask_set),
        .mask_clr  (mask_clr),
        .rb_go     (rb_go),
        .rb_is_cnt (rb_is_cnt)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic sel;
        assign sel = (int'(tgt_ch) == i);
        cp_chan_regs u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_port  (ld_port && sel),
            .ld_addr  (ld_addr && sel),
            .ld_cnt   (ld_cnt && sel),
            .ld_mode  (ld_mode && sel),
            .mask_set (mask_set && sel),
            .mask_clr (mask_clr && sel),
            .byte_idx (byte_idx),
            .wdata    (wdata),
            .port_q   (ch_port[i*PORT_W +: PORT_W]),
            .addr_q   (ch_addr[i*ADDR_W +: ADDR_W]),
            .cnt_q    (ch_count[i*CNT_W +: CNT_W]),
            .mode_q   (ch_mode[i*MODE_W +: MODE_W]),
            .mask_q   (ch_mask[i]),
            .active   (ch_active[i])
        );
    end

    cp_readback #(.NCH(NCH)) u_rb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .wr_en     (wr_en),
        .rb_go     (rb_go),
        .rb_is_cnt (rb_is_cnt),
        .ch        (tgt_ch),
        .byte_idx  (byte_idx),
        .addr_flat (ch_addr),
        .cnt_flat  (ch_count),
        .rdata     (rdata)
    );

endmodule

// File: rtl/cp_checker.sv
module cp_checker
    import dma_cp_pkg::*;
#(
    parameter int NCH = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  wr_en,
    input logic                  rd_en,
    input logic                  addr_sel,
    input logic [7:0]            wdata,
    input logic [7:0]            rdata,
    input logic [NCH*PORT_W-1:0] ch_port,
    input logic [NCH*ADDR_W-1:0] ch_addr,
    input logic [NCH*CNT_W-1:0]  ch_count,
    input logic [NCH*MODE_W-1:0] ch_mode,
    input logic [NCH-1:0]        ch_mask,
    input logic [NCH-1:0]        ch_active
);

    logic cmd_wr, known_op;
    assign cmd_wr   = wr_en && !addr_sel;
    assign known_op = wdata[7:4] inside {OP_LD_PORT, OP_LD_ADDR, OP_RB_ADDR, OP_LD_CNT,
                                         OP_RB_CNT, OP_LD_MODE, OP_MASK, OP_UNMASK};

    // R11
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !known_op |=> $stable(ch_port) && $stable(ch_addr) &&
            $stable(ch_count) && $stable(ch_mode) && $stable(ch_mask));

    // R8
    mask_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wdata[7:4] == OP_MASK && int'(wdata[3:0]) < NCH
            |=> ch_mask[$past(wdata[3:0])] && !ch_active[$past(wdata[3:0])]);

    // R8
    unmask_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && wdata[7:4] == OP_UNMASK && int'(wdata[3:0]) < NCH
            |=> !ch_mask[$past(wdata[3:0])]);

    // R12
    cmd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && !wr_en && !addr_sel |=> rdata == 8'h00);

    // R12
    hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ch_port) && $stable(ch_addr) && $stable(ch_count) &&
            $stable(ch_mode) && $stable(ch_mask));

    for (genvar i = 0; i < NCH; i++) begin : g_act
        // R9
        active_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ch_active[i]) |-> $past(wr_en) && !ch_mask[i]);
    end

endmodule

bind dma_cmdport_regs cp_checker #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr_sel  (addr_sel),
    .wdata     (wdata),
    .rdata     (rdata),
    .ch_port   (ch_port),
    .ch_addr   (ch_addr),
    .ch_count  (ch_count),
    .ch_mode   (ch_mode),
    .ch_mask   (ch_mask),
    .ch_active (ch_active)
);

// File: tb/tb_dma_cmdport_regs.sv
`timescale 1ns/1ps
module tb_dma_cmdport_regs;

    localparam int NCH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, addr_sel = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [NCH*16-1:0] ch_port;
    logic [NCH*24-1:0] ch_addr;
    logic [NCH*16-1:0] ch_count;
    logic [NCH*8-1:0]  ch_mode;
    logic [NCH-1:0]    ch_mask;
    logic [NCH-1:0]    ch_active;

    always #4 clk = ~clk;

    dma_cmdport_regs #(.NCH(NCH)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr_sel(addr_sel), .wdata(wdata), .rdata(rdata),
        .ch_port(ch_port), .ch_addr(ch_addr), .ch_count(ch_count),
        .ch_mode(ch_mode), .ch_mask(ch_mask), .ch_active(ch_active)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;
    string cur_req = "R1";

    // reference model
    int m_port[NCH], m_addr[NCH], m_cnt[NCH], m_mode[NCH];
    bit m_mask[NCH];
    int m_op = -1, m_ch = 0, m_ptr = 0, m_rd = 0;

    function automatic int op_len(int op);
        case (op)
            0, 4, 5: return 2;
            2, 3:    return 3;
            7:       return 1;
            default: return 0;
        endcase
    endfunction

    function automatic int put_byte(int v, int p, int b);
        return (v & ~(255 << (8 * p))) | (b << (8 * p));
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_port[i] = 0; m_addr[i] = 0; m_cnt[i] = 0; m_mode[i] = 0; m_mask[i] = 1;
        end
        m_op = -1; m_ptr = 0; m_rd = 0;
    endtask

    task automatic model_step(bit w, bit r, bit a, int d);
        if (w && !a) begin
            int op = d >> 4;
            m_ch = d & 15;
            m_ptr = 0;
            m_op = -1;
            if (op == 9) m_mask[m_ch] = 1;
            else if (op == 10) m_mask[m_ch] = 0;
            else if (op_len(op) > 0) m_op = op;
        end else if (w && a) begin
            if (m_op inside {0, 2, 4, 7} && m_ptr < op_len(m_op)) begin
                case (m_op)
                    0: m_port[m_ch] = put_byte(m_port[m_ch], m_ptr, d);
                    2: m_addr[m_ch] = put_byte(m_addr[m_ch], m_ptr, d);
                    4: m_cnt[m_ch]  = put_byte(m_cnt[m_ch], m_ptr, d);
                    default: m_mode[m_ch] = d;
                endcase
                m_ptr++;
            end
        end else if (r) begin
            if (a && m_op inside {3, 5} && m_ptr < op_len(m_op)) begin
                m_rd = (((m_op == 3) ? m_addr[m_ch] : m_cnt[m_ch]) >> (8 * m_ptr)) & 255;
                m_ptr++;
            end else begin
                m_rd = 0;
            end
        end
    endtask

    task automatic compare();
        string msg = "";
        n_chk++;
        if (int'(rdata) != m_rd) msg = $sformatf("rdata act=%02h exp=%02h", rdata, m_rd);
        for (int i = 0; i < NCH && msg == ""; i++) begin
            bit exp_act = !m_mask[i] && m_mode[i][2];
            if (int'(ch_port[i*16 +: 16]) != m_port[i])
                msg = $sformatf("ch%0d port act=%h exp=%h", i, ch_port[i*16 +: 16], m_port[i]);
            else if (int'(ch_addr[i*24 +: 24]) != m_addr[i])
                msg = $sformatf("ch%0d addr act=%h exp=%h", i, ch_addr[i*24 +: 24], m_addr[i]);
            else if (int'(ch_count[i*16 +: 16]) != m_cnt[i])
                msg = $sformatf("ch%0d count act=%h exp=%h", i, ch_count[i*16 +: 16], m_cnt[i]);
            else if (int'(ch_mode[i*8 +: 8]) != m_mode[i])
                msg = $sformatf("ch%0d mode act=%h exp=%h", i, ch_mode[i*8 +: 8], m_mode[i]);
            else if (ch_mask[i] != m_mask[i])
                msg = $sformatf("ch%0d mask act=%0d exp=%0d", i, ch_mask[i], m_mask[i]);
            else if (ch_active[i] != exp_act)
                msg = $sformatf("ch%0d active act=%0d exp=%0d", i, ch_active[i], exp_act);
        end
        if (msg != "") begin
            n_bad++;
            $display("FAIL %s cycle compare: %s", cur_req, msg);
        end
    endtask

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(bit w, bit r, bit a, logic [7:0] d);
        wr_en = w; rd_en = r; addr_sel = a; wdata = d;
        @(posedge clk);
        model_step(w, r, a, int'(d));
        #1;
        wr_en = 0; rd_en = 0; addr_sel = 0; wdata = 8'h00;
        @(negedge clk);
        compare();
    endtask

    task automatic cmd(logic [7:0] b);  step(1, 0, 0, b);     endtask
    task automatic dwr(logic [7:0] b);  step(1, 0, 1, b);     endtask
    task automatic drd();               step(0, 1, 1, 8'h00); endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare();
        // R1 reset state
        chk("R1 mask", int'(ch_mask), 16'hFFFF);
        chk("R1 addr ch0", int'(ch_addr[23:0]), 0);
        chk("R1 rdata", int'(rdata), 0);

        cur_req = "R3";
        cmd(8'h03); dwr(8'h34); dwr(8'h12);
        chk("R3 port ch3", int'(ch_port[3*16 +: 16]), 16'h1234);

        cur_req = "R4";
        cmd(8'h25); dwr(8'hEF); dwr(8'hCD); dwr(8'hAB);
        chk("R4 addr ch5", int'(ch_addr[5*24 +: 24]), 24'hABCDEF);
        cur_req = "R10";
        dwr(8'h99);
        chk("R10 extra write ignored", int'(ch_addr[5*24 +: 24]), 24'hABCDEF);

        cur_req = "R7";
        cmd(8'h35);
        drd(); chk("R7 addr byte0", int'(rdata), 8'hEF);
        drd(); chk("R7 addr byte1", int'(rdata), 8'hCD);
        drd(); chk("R7 addr byte2", int'(rdata), 8'hAB);
        cur_req = "R10";
        drd(); chk("R10 read past end", int'(rdata), 0);

        cur_req = "R5";
        cmd(8'h4F); dwr(8'hFF); dwr(8'hFF);
        chk("R5 count ch15 max", int'(ch_count[15*16 +: 16]), 16'hFFFF);
        cur_req = "R7";
        cmd(8'h5F); drd(); drd();
        chk("R7 count byte1", int'(rdata), 8'hFF);

        cur_req = "R6";
        cmd(8'h75); dwr(8'h44);
        chk("R6 mode ch5", int'(ch_mode[5*8 +: 8]), 8'h44);
        chk("R9 masked not active", int'(ch_active[5]), 0);
        cur_req = "R8";
        cmd(8'hA5);
        chk("R8 unmask ch5", int'(ch_mask[5]), 0);
        chk("R9 active ch5", int'(ch_active[5]), 1);
        cur_req = "R9";
        cmd(8'h75); dwr(8'h08);
        chk("R9 xfer bit clear", int'(ch_active[5]), 0);
        cmd(8'h75); dwr(8'h0D);
        chk("R9 active again", int'(ch_active[5]), 1);
        cur_req = "R8";
        cmd(8'h95);
        chk("R8 mask ch5", int'(ch_mask[5]), 1);
        chk("R9 mask kills active", int'(ch_active[5]), 0);

        cur_req = "R11";
        cmd(8'h75); cmd(8'h65); dwr(8'h11);
        chk("R11 unknown op closes seq", int'(ch_mode[5*8 +: 8]), 8'h0D);
        for (int op = 11; op < 16; op++) begin
            cmd(8'((op << 4) | 5)); dwr(8'h22);
        end
        cmd(8'h15); dwr(8'h33); cmd(8'h85); dwr(8'h44);
        chk("R11 addr untouched", int'(ch_addr[5*24 +: 24]), 24'hABCDEF);

        cur_req = "R2";
        cmd(8'h22); dwr(8'h55); cmd(8'h22); dwr(8'h11); dwr(8'h22); dwr(8'h33);
        chk("R2 pointer restart", int'(ch_addr[2*24 +: 24]), 24'h332211);

        cur_req = "R10";
        cmd(8'h35); dwr(8'h77);
        chk("R10 write in readback", int'(ch_addr[5*24 +: 24]), 24'hABCDEF);
        cmd(8'h02); drd();
        chk("R10 read in load", int'(rdata), 0);
        chk("R10 port ch2 untouched", int'(ch_port[2*16 +: 16]), 0);

        cur_req = "R12";
        cmd(8'h35); drd();
        chk("R12 pre nonzero rdata", int'(rdata), 8'hEF);
        step(0, 1, 0, 8'h00);
        chk("R12 cmd port read", int'(rdata), 0);
        repeat (3) step(0, 0, 0, 8'h00);
        chk("R12 hold", int'(ch_port[3*16 +: 16]), 16'h1234);

        cur_req = "R2";
        for (int k = 0; k < 400; k++) begin
            int sel = $urandom_range(0, 3);
            if (sel == 0) cmd(8'($urandom_range(0, 255)));
            else if (sel == 1) drd();
            else dwr(8'($urandom_range(0, 255)));
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule